// File: doc/BRIEF.md
# Five-Stage In-Order Pipeline with Read-After-Write Interlock

This block is a small in-order, single-issue pipeline that executes three-register ALU operations of the form `Rd = Rs op Rt`. Each instruction moves through five stages: fetch, decode, operand fetch, execute and write-back. There is no bypass network. Instead, an interlock keeps any instruction that reads a register still being produced by an older instruction in decode. It stays there until the producer has written the register file. The register file is written at the end of write-back and is read in operand fetch during a later cycle.

The block drives a fetch address to an instruction memory outside the block and takes the instruction word back in the same cycle. It exposes the whole architectural register file as one flat vector. It also has a stall flag that is high in every cycle a decoded instruction is held, and a retire strobe that pulses once for each valid instruction in its write-back cycle. During a stall, the fetch address and the decode register keep their values. A bubble goes into operand fetch, and the older instructions ahead of the held one keep moving.

Top module: `pl_interlock_top`

## Requirements
- R1: An instruction word is 12 bits: bit 11 valid, bits 10:9 opcode, bits 8:6 destination, bits 5:3 first source, bits 2:0 second source. The opcodes are 0 add, 1 subtract (first minus second), 2 bitwise AND, 3 bitwise XOR, all modulo 2^16. A valid instruction writes the result to its destination register. A word with the valid bit clear changes no register and does not retire.
- R2: After reset, register i (for i from 1 to 7) holds 3*i+1, register 0 holds 0, and both stall and retire are low.
- R3: Register 0 always reads as zero, and writes to it are discarded. An instruction that reads only register 0 is never stalled, even when an older in-flight instruction names register 0 as its destination.
- R4: When a consumer directly follows its producer (dependency distance 1), the consumer enters operand fetch, and therefore retires, exactly two cycles later than it would without the dependency.
- R5: At dependency distance 2, the consumer is delayed by exactly one cycle.
- R6: At dependency distance 3 or more, the consumer is not delayed, and it retires one cycle after the instruction before it.
- R7: The stall output is high in each cycle a valid instruction is held in decode, and a bubble enters operand fetch in that cycle. Over a program, the number of stall cycles equals the total delay added by all dependencies.
- R8: Instructions retire in program order, at most one per cycle, with exactly one retire pulse for each valid instruction.
- R9: While stall is high, the fetch address does not advance in the following cycle, so every instruction behind the held one is held as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | PCW (6) | Fetch address to the instruction memory |
| imem_data | input | IW (12) | Instruction word at imem_addr, same cycle |
| rf_flat | output | NREG*DW (128) | Register file; register i occupies bits i*DW+DW-1 down to i*DW |
| stall | output | 1 | High while the decoded instruction is held |
| retire | output | 1 | Pulses in the write-back cycle of each valid instruction |

## Verification
An instruction with no pending producer enters operand fetch one cycle after decode and retires two cycles after that. A dependency at distance d (1 or 2) pushes that retirement back by 3-d cycles, counted from the producer's entry into operand fetch. The bench builds this schedule arithmetically for each program and compares every retire cycle, measured from the first retirement, against it. It samples on the falling edge so that the registered retire and stall values of the current cycle are read. The register file is compared with an in-order arithmetic model three cycles after the last expected retirement, once all writes are complete. Stall cycles and fetch-address holds are counted cycle by cycle against the delays that the schedule predicts.

// File: rtl/pl_pkg.sv
package pl_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_XOR = 2'd3
    } alu_op_e;
endpackage

// File: rtl/pl_alu.sv
module pl_alu
    import pl_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            default: y = a ^ b;
        endcase
    end
endmodule

// File: rtl/pl_regfile.sv
module pl_regfile #(
    parameter  int DW   = 16,
    parameter  int NREG = 8,
    localparam int RAW  = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [RAW-1:0]       waddr,
    input  logic [DW-1:0]        wdata,
    input  logic [RAW-1:0]       raddr_a,
    input  logic [RAW-1:0]       raddr_b,
    output logic [DW-1:0]        rdata_a,
    output logic [DW-1:0]        rdata_b,
    output logic [NREG*DW-1:0]   flat
);
    logic [DW-1:0] mem_q [NREG];
    logic [DW-1:0] mem_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) mem_d[i] = mem_q[i];
        if (we && (waddr != '0)) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++)
                mem_q[i] <= (i == 0) ? '0 : DW'(3 * i + 1);
        end else begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata_a = (raddr_a == '0) ? '0 : mem_q[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : mem_q[raddr_b];

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign flat[g*DW +: DW] = mem_q[g];
    end
endmodule

// File: rtl/pl_hazard.sv
module pl_hazard #(
    parameter int RAW  = 3,
    parameter int NSTG = 2
) (
    input  logic                      src_valid,
    input  logic [RAW-1:0]            src_a,
    input  logic [RAW-1:0]            src_b,
    input  logic [NSTG-1:0]           dst_valid,
    input  logic [NSTG-1:0][RAW-1:0]  dst,
    output logic                      hit
);
    logic [NSTG-1:0] match;

    for (genvar k = 0; k < NSTG; k++) begin : g_cmp
        assign match[k] = dst_valid[k] && (dst[k] != '0) &&
                          ((dst[k] == src_a) || (dst[k] == src_b));
    end

    assign hit = src_valid && (|match);
endmodule

// File: rtl/pl_interlock_top.sv
module pl_interlock_top
    import pl_pkg::*;
#(
    parameter  int DW   = 16,
    parameter  int NREG = 8,
    parameter  int PCW  = 6,
    localparam int RAW  = $clog2(NREG),
    localparam int IW   = 3 + 3 * RAW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [PCW-1:0]       imem_addr,
    input  logic [IW-1:0]        imem_data,
    output logic [NREG*DW-1:0]   rf_flat,
    output logic                 stall,
    output logic                 retire
);
    localparam int NSTG = 2;

    typedef struct packed {
        logic           valid;
        alu_op_e        op;
        logic [RAW-1:0] rd;
        logic [RAW-1:0] rs;
        logic [RAW-1:0] rt;
    } dec_t;

    typedef struct packed {
        logic           valid;
        alu_op_e        op;
        logic [RAW-1:0] rd;
        logic [DW-1:0]  a;
        logic [DW-1:0]  b;
    } opr_t;

    typedef struct packed {
        logic           valid;
        logic [RAW-1:0] rd;
        logic [DW-1:0]  res;
    } res_t;

    typedef struct packed {
        logic [PCW-1:0] pc;
        dec_t           fd;
        dec_t           od;
        opr_t           ex;
        res_t           wb;
    } pipe_t;

    pipe_t pipe_q, pipe_d;

    logic [DW-1:0]              rd_a, rd_b, alu_y;
    logic                       hz_hit;
    logic [NSTG-1:0]            dst_valid_w;
    logic [NSTG-1:0][RAW-1:0]   dst_w;

    logic                       fd_valid_w;
    logic [RAW-1:0]             fd_rs_w, fd_rt_w;
    logic                       od_valid_w;

    assign dst_valid_w = {pipe_q.ex.valid, pipe_q.od.valid};
    assign dst_w       = {pipe_q.ex.rd, pipe_q.od.rd};

    pl_hazard #(.RAW(RAW), .NSTG(NSTG)) u_hazard (
        .src_valid (pipe_q.fd.valid),
        .src_a     (pipe_q.fd.rs),
        .src_b     (pipe_q.fd.rt),
        .dst_valid (dst_valid_w),
        .dst       (dst_w),
        .hit       (hz_hit)
    );

    pl_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (pipe_q.wb.valid),
        .waddr   (pipe_q.wb.rd),
        .wdata   (pipe_q.wb.res),
        .raddr_a (pipe_q.od.rs),
        .raddr_b (pipe_q.od.rt),
        .rdata_a (rd_a),
        .rdata_b (rd_b),
        .flat    (rf_flat)
    );

    pl_alu #(.DW(DW)) u_alu (
        .op (pipe_q.ex.op),
        .a  (pipe_q.ex.a),
        .b  (pipe_q.ex.b),
        .y  (alu_y)
    );

    always_comb begin
        pipe_d = pipe_q;
        // fetch and decode advance only when the decoded word has no pending producer
        if (!hz_hit) begin
            pipe_d.pc = pipe_q.pc + PCW'(1);
            pipe_d.fd = dec_t'(imem_data);
            pipe_d.od = pipe_q.fd;
        end else begin
            pipe_d.od = '0;
        end
        // operand fetch: register file read after any earlier write-back
        pipe_d.ex.valid = pipe_q.od.valid;
        pipe_d.ex.op    = pipe_q.od.op;
        pipe_d.ex.rd    = pipe_q.od.rd;
        pipe_d.ex.a     = rd_a;
        pipe_d.ex.b     = rd_b;
        // execute
        pipe_d.wb.valid = pipe_q.ex.valid;
        pipe_d.wb.rd    = pipe_q.ex.rd;
        pipe_d.wb.res   = alu_y;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign imem_addr  = pipe_q.pc;
    assign stall      = hz_hit;
    assign retire     = pipe_q.wb.valid;

    assign fd_valid_w = pipe_q.fd.valid;
    assign fd_rs_w    = pipe_q.fd.rs;
    assign fd_rt_w    = pipe_q.fd.rt;
    assign od_valid_w = pipe_q.od.valid;
endmodule

// File: rtl/pl_interlock_chk.sv
module pl_interlock_chk #(
    parameter int PCW = 6,
    parameter int RAW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           stall,
    input logic [PCW-1:0] imem_addr,
    input logic           fd_valid,
    input logic [RAW-1:0] fd_rs,
    input logic [RAW-1:0] fd_rt,
    input logic           od_valid
);
    // R9
    hold_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(imem_addr));

    // R7
    bubble_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !od_valid);

    // R6
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fd_valid && !stall) |=> od_valid);

    // R3
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fd_valid && (fd_rs == '0) && (fd_rt == '0)) |-> !stall);
endmodule

bind pl_interlock_top pl_interlock_chk #(.PCW(PCW), .RAW(RAW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .imem_addr (imem_addr),
    .fd_valid  (fd_valid_w),
    .fd_rs     (fd_rs_w),
    .fd_rt     (fd_rt_w),
    .od_valid  (od_valid_w)
);

// File: tb/pl_interlock_top_bench.sv
module pl_interlock_top_bench;
    localparam int DW = 16, NREG = 8, PCW = 6, IW = 12, MAXP = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                 rst_n;
    logic [PCW-1:0]       imem_addr;
    logic [IW-1:0]        imem_data;
    logic [NREG*DW-1:0]   rf_flat;
    logic                 stall, retire;

    logic [IW-1:0] prog [MAXP];
    int plen;
    int total = 0, bad = 0;

    assign imem_data = (int'(imem_addr) < plen) ? prog[imem_addr[3:0]] : '0;

    pl_interlock_top u_pl_interlock_top (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .rf_flat(rf_flat), .stall(stall), .retire(retire)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [IW-1:0] mk(int op, int rd, int rs, int rt);
        return {1'b1, 2'(op), 3'(rd), 3'(rs), 3'(rt)};
    endfunction

    function automatic int alu(int op, int a, int b);
        case (op)
            0: return (a + b) & 16'hFFFF;
            1: return (a - b) & 16'hFFFF;
            2: return a & b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic run_prog(string tag);
        int ref_rf [NREG];
        int e [MAXP];
        int vidx [MAXP];
        int stamp [MAXP];
        int nvalid, cyc, rc, stalls, exp_stalls, prev_addr;
        bit prev_stall;
        for (int i = 0; i < NREG; i++) ref_rf[i] = (i == 0) ? 0 : 3 * i + 1;
        nvalid = 0;
        for (int i = 0; i < plen; i++) begin
            e[i] = (i == 0) ? 0 : e[i-1] + 1;
            if (prog[i][11]) begin
                for (int j = 0; j < i; j++) begin
                    if (prog[j][11] && prog[j][8:6] != 0 &&
                        (prog[j][8:6] == prog[i][5:3] || prog[j][8:6] == prog[i][2:0]) &&
                        e[j] + 3 > e[i])
                        e[i] = e[j] + 3;
                end
                vidx[nvalid] = i;
                nvalid++;
                if (prog[i][8:6] != 0)
                    ref_rf[prog[i][8:6]] = alu(int'(prog[i][10:9]),
                        ref_rf[prog[i][5:3]], ref_rf[prog[i][2:0]]);
            end
        end
        exp_stalls = e[plen-1] - (plen - 1);

        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R2 reset state
        for (int i = 0; i < NREG; i++)
            chk(int'(rf_flat[i*DW +: DW]) == ((i == 0) ? 0 : 3 * i + 1), "R2", "reset reg",
                int'(rf_flat[i*DW +: DW]), (i == 0) ? 0 : 3 * i + 1);
        chk(!stall && !retire, "R2", "reset stall/retire", int'({stall, retire}), 0);
        rst_n = 1'b1;

        cyc = 0; rc = 0; stalls = 0; prev_stall = 1'b0; prev_addr = 0;
        while (rc < nvalid && cyc < 300) begin
            @(negedge clk);
            cyc++;
            if (prev_stall)
                chk(int'(imem_addr) == prev_addr, "R9", "fetch held", int'(imem_addr), prev_addr);
            if (retire) begin
                stamp[rc] = cyc;
                rc++;
            end
            if (stall) stalls++;
            prev_stall = stall;
            prev_addr  = int'(imem_addr);
        end
        chk(rc == nvalid, "R8", "retire count", rc, nvalid);
        for (int k = 1; k < rc; k++)
            chk(stamp[k] - stamp[0] == e[vidx[k]] - e[vidx[0]], tag, "retire offset",
                stamp[k] - stamp[0], e[vidx[k]] - e[vidx[0]]);
        repeat (3) @(negedge clk);
        if (stall) stalls++;
        chk(stalls == exp_stalls, "R7", "stall cycles", stalls, exp_stalls);
        for (int i = 0; i < NREG; i++)
            chk(int'(rf_flat[i*DW +: DW]) == ref_rf[i], {"R1/", tag}, "final reg",
                int'(rf_flat[i*DW +: DW]), ref_rf[i]);
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        plen  = 0;

        // R4 back-to-back pair
        prog[0] = mk(0, 1, 2, 3);
        prog[1] = mk(1, 4, 1, 2);
        plen = 2;
        run_prog("R4");

        // sweep: distance 1..4, source slot, opcode
        for (int d = 1; d <= 4; d++) begin
            for (int slot = 0; slot < 3; slot++) begin
                for (int op = 0; op < 4; op++) begin
                    plen = 0;
                    prog[plen++] = mk(op, 5, 2, 3);
                    for (int f = 1; f < d; f++) prog[plen++] = mk((op + f) % 4, 6, 1, 2);
                    prog[plen++] = mk(3 - op, 4, (slot == 1) ? 1 : 5, (slot == 0) ? 2 : 5);
                    prog[plen++] = mk(3, 7, 1, 2);
                    run_prog((d == 1) ? "R4" : (d == 2) ? "R5" : "R6");
                end
            end
        end

        // R3 register zero
        prog[0] = mk(0, 0, 1, 2);
        prog[1] = mk(0, 3, 0, 1);
        prog[2] = mk(3, 5, 0, 0);
        plen = 3;
        run_prog("R3");

        // R1 invalid word in between
        prog[0] = mk(0, 1, 2, 3);
        prog[1] = mk(1, 1, 4, 5) & 12'h7FF;
        prog[2] = mk(2, 2, 1, 3);
        plen = 3;
        run_prog("R1");

        // R7 long chain, each one depends on the previous
        for (int i = 0; i < 7; i++) prog[i] = mk(i % 4, 1, 1, 2);
        prog[7] = mk(0, 3, 4, 5);
        plen = 8;
        run_prog("R8");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule